// File: doc/BRIEF.md
# Branch-Guided Run-Ahead Prefetch Controller

This controller keeps a speculative program counter ahead of the processor's program counter. Each cycle it looks at a short group of sequential instruction slots starting at that counter. For every slot it sends out a lookup address. The branch target buffer, the branch predictor and the load tracking table answer those lookups in the same cycle.

A slot that the branch target buffer recognises is a branch, and the controller follows its predicted outcome. Calls and returns go through a private return address stack, because the controller does not share the processor's counter. A slot that the load table recognises is a load. It is prefetched when two conditions hold: the load is confident on both counters, and its predicted address falls in a different cache line from its last address. A slot that neither structure recognises is stepped over.

The controller never runs more than a fixed number of instructions ahead of the processor. It jumps back to the correct path on every misprediction, and also whenever the processor overtakes it. Prefetch requests leave through a valid/ready handshake. While a request is waiting to be accepted, the walk holds.

Top module: `runahead_pf_ctrl`

## Requirements
- R1: After reset, `pf_valid_o` is 0 and slot 0 of `lookup_pc_o` equals the parameter `RESET_PC`.
- R2: Slot k of `lookup_pc_o` (bits k*PC_W upward) always equals the run-ahead PC plus 4*k.
- R3: Slots that hit in neither the branch target buffer nor the load table are skipped. With no hits and enough headroom, the run-ahead PC advances by 4*WALK bytes per cycle.
- R4: Branch kind encoding per slot (`br_kind_i` bits 2k+1:2k) is 0 conditional, 1 call, 2 return, 3 jump. A conditional branch with `br_taken_i` set, or any jump, ends the walk at that slot. The next PC is `br_target_i`, and later slots in the group have no effect.
- R5: A conditional branch predicted not taken does not stop the walk.
- R6: A load-table hit issues a prefetch of `ld_pred_addr_i` when three things hold: both confidence inputs are 1, no earlier slot ended the walk, and the predicted address and `ld_last_addr_i` lie in different LINE_BYTES-aligned lines. The walk then ends after that slot. Failing any one of these conditions gives no prefetch, and the walk continues.
- R7: Let the lead be (run-ahead PC − processor PC)/4. Only min(WALK, MAX_AHEAD − lead) slots are walked. At a lead of MAX_AHEAD or more, the PC holds.
- R8: When `mispredict_i` is set, the next run-ahead PC is `fix_pc_i` and the return stack is emptied. This has priority over every other update.
- R9: If the processor PC is above the run-ahead PC (the difference is negative as a signed value), the next run-ahead PC is the processor PC and the return stack is emptied.
- R10: A call is always taken. It pushes its slot address + 4 and goes to `br_target_i`. A return is always taken. It goes to the popped address, or to `br_target_i` when the stack is empty.
- R11: The return stack holds RAS_DEPTH (8) entries. On overflow it overwrites the oldest entry, so after 9 calls the 9th return finds the stack empty.
- R12: While `pf_valid_o` is 1 and `pf_ready_i` is 0, `pf_addr_o` and `pf_valid_o` stay stable and the run-ahead PC does not advance. An accepted request with no new fire clears `pf_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proc_pc_i | input | PC_W | Processor program counter |
| mispredict_i | input | 1 | Branch misprediction pulse |
| fix_pc_i | input | PC_W | Correct PC after a misprediction |
| lookup_pc_o | output | WALK*PC_W | Lookup address of each slot |
| btb_hit_i | input | WALK | Slot is a known branch |
| br_kind_i | input | 2*WALK | Branch kind per slot |
| br_taken_i | input | WALK | Predicted direction per slot |
| br_target_i | input | WALK*PC_W | Predicted target per slot |
| ld_hit_i | input | WALK | Slot is a tracked load |
| ld_miss_conf_i | input | WALK | Miss-count confidence reached |
| ld_addr_conf_i | input | WALK | Address-prediction confidence reached |
| ld_last_addr_i | input | WALK*PC_W | Last data address of the load |
| ld_pred_addr_i | input | WALK*PC_W | Predicted next data address |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | PC_W | Prefetch address |
| pf_ready_i | input | 1 | Prefetch request accepted |

## Verification
The hardest states to reach are return-stack overflow and a return that finds the stack empty. Reaching them takes a long chain of calls that the walk actually follows, with no resync in between, since any resync would empty the stack. A directed sequence builds that chain. It keeps the processor PC level with the run-ahead PC, so that neither the distance cap nor the lag resync cuts in. Then it unwinds all nine returns. A seeded random phase mixes the remaining cases: hits, stalls on the handshake, lag and mispredictions. Every cycle of that phase is compared against a stack-shifting reference model in the bench.

// File: rtl/runahead_pkg.sv
package runahead_pkg;
  localparam int unsigned INST_BYTES = 4;
  localparam int unsigned INST_SH    = 2;

  typedef enum logic [1:0] {
    BR_COND = 2'd0,
    BR_CALL = 2'd1,
    BR_RET  = 2'd2,
    BR_JUMP = 2'd3
  } br_kind_e;
endpackage

// File: rtl/runahead_gap.sv
module runahead_gap
  import runahead_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned WALK      = 4,
  parameter int unsigned MAX_AHEAD = 100,
  parameter int unsigned CNT_W     = $clog2(WALK + 1)
) (
  input  logic [PC_W-1:0]  ra_pc_i,
  input  logic [PC_W-1:0]  proc_pc_i,
  output logic             behind_o,
  output logic [CNT_W-1:0] slots_o
);
  logic [PC_W-1:0] diff;
  logic [PC_W-1:0] lead;
  logic [PC_W-1:0] room;

  assign diff     = ra_pc_i - proc_pc_i;
  assign behind_o = diff[PC_W-1];
  assign lead     = diff >> INST_SH;
  assign room     = PC_W'(MAX_AHEAD) - lead;

  always_comb begin
    if (behind_o || lead >= PC_W'(MAX_AHEAD)) slots_o = '0;
    else if (room >= PC_W'(WALK))            slots_o = CNT_W'(WALK);
    else                                      slots_o = room[CNT_W-1:0];
  end
endmodule

// File: rtl/runahead_ras.sv
module runahead_ras #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_addr_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] top_o,
  output logic            nonempty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign top_o      = mem_q[wr_ptr_q - PTR_W'(1)];
  assign nonempty_o = cnt_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && nonempty_o) begin
      wr_ptr_q <= wr_ptr_q - PTR_W'(1);
      cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

  // oldest entry is overwritten on wrap
  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_ptr_q] <= push_addr_i;
  end
endmodule

// File: rtl/runahead_walk.sv
module runahead_walk
  import runahead_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned WALK    = 4,
  parameter int unsigned LINE_SH = 6,
  parameter int unsigned CNT_W   = $clog2(WALK + 1)
) (
  input  logic [PC_W-1:0]      base_pc_i,
  input  logic [CNT_W-1:0]     slots_i,
  input  logic [WALK-1:0]      btb_hit_i,
  input  logic [2*WALK-1:0]    br_kind_i,
  input  logic [WALK-1:0]      br_taken_i,
  input  logic [WALK*PC_W-1:0] br_target_i,
  input  logic [WALK-1:0]      ld_hit_i,
  input  logic [WALK-1:0]      ld_miss_conf_i,
  input  logic [WALK-1:0]      ld_addr_conf_i,
  input  logic [WALK*PC_W-1:0] ld_last_addr_i,
  input  logic [WALK*PC_W-1:0] ld_pred_addr_i,
  input  logic [PC_W-1:0]      ras_top_i,
  input  logic                 ras_nonempty_i,
  output logic [PC_W-1:0]      next_pc_o,
  output logic                 push_o,
  output logic [PC_W-1:0]      push_addr_o,
  output logic                 pop_o,
  output logic                 fire_o,
  output logic [PC_W-1:0]      fire_addr_o
);
  always_comb begin
    logic            done;
    logic [PC_W-1:0] spc;
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] last_a;
    logic [PC_W-1:0] pred_a;
    br_kind_e        kind;

    next_pc_o   = base_pc_i;
    push_o      = 1'b0;
    push_addr_o = '0;
    pop_o       = 1'b0;
    fire_o      = 1'b0;
    fire_addr_o = '0;
    done        = 1'b0;
    for (int k = 0; k < int'(WALK); k++) begin
      spc    = base_pc_i + PC_W'(k * INST_BYTES);
      tgt    = br_target_i[k*PC_W +: PC_W];
      last_a = ld_last_addr_i[k*PC_W +: PC_W];
      pred_a = ld_pred_addr_i[k*PC_W +: PC_W];
      kind   = br_kind_e'(br_kind_i[2*k +: 2]);
      if (!done && k < int'(slots_i)) begin
        next_pc_o = spc + PC_W'(INST_BYTES);
        if (btb_hit_i[k]) begin
          unique case (kind)
            BR_COND: if (br_taken_i[k]) begin
              next_pc_o = tgt;
              done      = 1'b1;
            end
            BR_JUMP: begin
              next_pc_o = tgt;
              done      = 1'b1;
            end
            BR_CALL: begin
              push_o      = 1'b1;
              push_addr_o = spc + PC_W'(INST_BYTES);
              next_pc_o   = tgt;
              done        = 1'b1;
            end
            BR_RET: begin
              pop_o     = ras_nonempty_i;
              next_pc_o = ras_nonempty_i ? ras_top_i : tgt;
              done      = 1'b1;
            end
            default: ;
          endcase
        end else if (ld_hit_i[k] && ld_miss_conf_i[k] && ld_addr_conf_i[k] &&
                     (last_a >> LINE_SH) != (pred_a >> LINE_SH)) begin
          fire_o      = 1'b1;
          fire_addr_o = pred_a;
          done        = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/runahead_pf_ctrl.sv
module runahead_pf_ctrl
  import runahead_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     WALK       = 4,
  parameter int unsigned     MAX_AHEAD  = 100,
  parameter int unsigned     LINE_BYTES = 64,
  parameter int unsigned     RAS_DEPTH  = 8,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PC_W-1:0]      proc_pc_i,
  input  logic                 mispredict_i,
  input  logic [PC_W-1:0]      fix_pc_i,
  output logic [WALK*PC_W-1:0] lookup_pc_o,
  input  logic [WALK-1:0]      btb_hit_i,
  input  logic [2*WALK-1:0]    br_kind_i,
  input  logic [WALK-1:0]      br_taken_i,
  input  logic [WALK*PC_W-1:0] br_target_i,
  input  logic [WALK-1:0]      ld_hit_i,
  input  logic [WALK-1:0]      ld_miss_conf_i,
  input  logic [WALK-1:0]      ld_addr_conf_i,
  input  logic [WALK*PC_W-1:0] ld_last_addr_i,
  input  logic [WALK*PC_W-1:0] ld_pred_addr_i,
  output logic                 pf_valid_o,
  output logic [PC_W-1:0]      pf_addr_o,
  input  logic                 pf_ready_i
);
  localparam int unsigned CNT_W   = $clog2(WALK + 1);
  localparam int unsigned LINE_SH = $clog2(LINE_BYTES);

  logic [PC_W-1:0]  ra_pc_q;
  logic             pf_valid_q;
  logic [PC_W-1:0]  pf_addr_q;
  logic             behind;
  logic [CNT_W-1:0] slots;
  logic [PC_W-1:0]  next_pc;
  logic             push, pop, fire;
  logic [PC_W-1:0]  push_addr, fire_addr;
  logic [PC_W-1:0]  ras_top;
  logic             ras_nonempty;
  logic             resync, walk_go;

  for (genvar g = 0; g < int'(WALK); g++) begin : g_lookup
    assign lookup_pc_o[g*PC_W +: PC_W] = ra_pc_q + PC_W'(g * INST_BYTES);
  end

  runahead_gap #(
    .PC_W(PC_W), .WALK(WALK), .MAX_AHEAD(MAX_AHEAD), .CNT_W(CNT_W)
  ) u_gap (
    .ra_pc_i  (ra_pc_q),
    .proc_pc_i(proc_pc_i),
    .behind_o (behind),
    .slots_o  (slots)
  );

  runahead_walk #(
    .PC_W(PC_W), .WALK(WALK), .LINE_SH(LINE_SH), .CNT_W(CNT_W)
  ) u_walk (
    .base_pc_i     (ra_pc_q),
    .slots_i       (slots),
    .btb_hit_i     (btb_hit_i),
    .br_kind_i     (br_kind_i),
    .br_taken_i    (br_taken_i),
    .br_target_i   (br_target_i),
    .ld_hit_i      (ld_hit_i),
    .ld_miss_conf_i(ld_miss_conf_i),
    .ld_addr_conf_i(ld_addr_conf_i),
    .ld_last_addr_i(ld_last_addr_i),
    .ld_pred_addr_i(ld_pred_addr_i),
    .ras_top_i     (ras_top),
    .ras_nonempty_i(ras_nonempty),
    .next_pc_o     (next_pc),
    .push_o        (push),
    .push_addr_o   (push_addr),
    .pop_o         (pop),
    .fire_o        (fire),
    .fire_addr_o   (fire_addr)
  );

  assign resync  = mispredict_i || behind;
  assign walk_go = !resync && !(pf_valid_q && !pf_ready_i);

  runahead_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (resync),
    .push_i     (walk_go && push),
    .push_addr_i(push_addr),
    .pop_i      (walk_go && pop),
    .top_o      (ras_top),
    .nonempty_o (ras_nonempty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_pc_q    <= RESET_PC;
      pf_valid_q <= 1'b0;
      pf_addr_q  <= '0;
    end else begin
      if (mispredict_i)  ra_pc_q <= fix_pc_i;
      else if (behind)   ra_pc_q <= proc_pc_i;
      else if (walk_go)  ra_pc_q <= next_pc;

      if (pf_valid_q && pf_ready_i) pf_valid_q <= 1'b0;
      if (walk_go && fire) begin
        pf_valid_q <= 1'b1;
        pf_addr_q  <= fire_addr;
      end
    end
  end

  assign pf_valid_o = pf_valid_q;
  assign pf_addr_o  = pf_addr_q;
endmodule

// File: rtl/runahead_pf_ctrl_chk.sv
module runahead_pf_ctrl_chk
  import runahead_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned WALK      = 4,
  parameter int unsigned MAX_AHEAD = 100
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [PC_W-1:0]      proc_pc_i,
  input logic                 mispredict_i,
  input logic [PC_W-1:0]      fix_pc_i,
  input logic [WALK*PC_W-1:0] lookup_pc_o,
  input logic                 pf_valid_o,
  input logic [PC_W-1:0]      pf_addr_o,
  input logic                 pf_ready_i
);
  logic [PC_W-1:0] ra, diff, lead;
  logic            behind;
  assign ra     = lookup_pc_o[PC_W-1:0];
  assign diff   = ra - proc_pc_i;
  assign behind = diff[PC_W-1];
  assign lead   = diff >> INST_SH;

  assert_pf_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_addr_o)));

  assert_walk_stall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i && !mispredict_i && !behind) |=> $stable(ra));

  assert_resync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i |=> (ra == $past(fix_pc_i)));

  assert_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mispredict_i && behind) |=> (ra == $past(proc_pc_i)));

  assert_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mispredict_i && !behind && lead >= PC_W'(MAX_AHEAD)) |=> $stable(ra));
endmodule

bind runahead_pf_ctrl runahead_pf_ctrl_chk #(
  .PC_W(PC_W), .WALK(WALK), .MAX_AHEAD(MAX_AHEAD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .proc_pc_i   (proc_pc_i),
  .mispredict_i(mispredict_i),
  .fix_pc_i    (fix_pc_i),
  .lookup_pc_o (lookup_pc_o),
  .pf_valid_o  (pf_valid_o),
  .pf_addr_o   (pf_addr_o),
  .pf_ready_i  (pf_ready_i)
);

// File: tb/runahead_pf_ctrl_bench.sv
module runahead_pf_ctrl_bench;
  localparam int          PC_W       = 32;
  localparam int          WALK       = 4;
  localparam int          MAX_AHEAD  = 100;
  localparam int          LINE_BYTES = 64;
  localparam int          RAS_DEPTH  = 8;
  localparam logic [31:0] RESET_PC   = 32'h0000_1000;
  localparam int          CLK_PERIOD = 10;
  localparam logic [1:0]  K_COND = 2'd0, K_CALL = 2'd1, K_RET = 2'd2, K_JUMP = 2'd3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [PC_W-1:0]      proc_pc = '0;
  logic                 mispredict = 1'b0;
  logic [PC_W-1:0]      fix_pc = '0;
  logic [WALK*PC_W-1:0] lookup_pc;
  logic [WALK-1:0]      btb_hit, br_taken, ld_hit, ld_mc, ld_ac;
  logic [2*WALK-1:0]    br_kind;
  logic [WALK*PC_W-1:0] br_target, ld_last, ld_pred;
  logic                 pf_valid;
  logic [PC_W-1:0]      pf_addr;
  logic                 pf_ready = 1'b1;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_pc;
  logic        m_pfv;
  logic [31:0] m_pfa;
  logic [31:0] m_stk [RAS_DEPTH];
  int          m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  runahead_pf_ctrl #(
    .PC_W(PC_W), .WALK(WALK), .MAX_AHEAD(MAX_AHEAD), .LINE_BYTES(LINE_BYTES),
    .RAS_DEPTH(RAS_DEPTH), .RESET_PC(RESET_PC)
  ) u_runahead_pf_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .proc_pc_i(proc_pc), .mispredict_i(mispredict),
    .fix_pc_i(fix_pc), .lookup_pc_o(lookup_pc), .btb_hit_i(btb_hit),
    .br_kind_i(br_kind), .br_taken_i(br_taken), .br_target_i(br_target),
    .ld_hit_i(ld_hit), .ld_miss_conf_i(ld_mc), .ld_addr_conf_i(ld_ac),
    .ld_last_addr_i(ld_last), .ld_pred_addr_i(ld_pred),
    .pf_valid_o(pf_valid), .pf_addr_o(pf_addr), .pf_ready_i(pf_ready)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_resp();
    btb_hit = '0; br_taken = '0; ld_hit = '0; ld_mc = '0; ld_ac = '0;
    br_kind = '0; br_target = '0; ld_last = '0; ld_pred = '0;
  endtask

  task automatic set_br(input int k, input logic [1:0] kind, input logic tk, input logic [31:0] tgt);
    btb_hit[k] = 1'b1; br_kind[2*k +: 2] = kind; br_taken[k] = tk;
    br_target[k*PC_W +: PC_W] = tgt;
  endtask

  task automatic set_ld(input int k, input logic mc, input logic ac,
                        input logic [31:0] last, input logic [31:0] pred);
    ld_hit[k] = 1'b1; ld_mc[k] = mc; ld_ac[k] = ac;
    ld_last[k*PC_W +: PC_W] = last; ld_pred[k*PC_W +: PC_W] = pred;
  endtask

  function automatic logic [31:0] slot_pc(input int k);
    return lookup_pc[k*PC_W +: PC_W];
  endfunction

  // reference model: shifting stack, index 0 is the top
  task automatic m_step();
    logic [31:0] diff, gap, npc, spc, tgt, faddr;
    int allow;
    bit stall, fire;
    stall = m_pfv && !pf_ready;
    fire  = 1'b0;
    faddr = '0;
    if (m_pfv && pf_ready) m_pfv = 1'b0;
    diff = m_pc - proc_pc;
    npc  = m_pc;
    if (mispredict) begin
      npc = fix_pc; m_cnt = 0;
    end else if (diff[31]) begin
      npc = proc_pc; m_cnt = 0;
    end else if (!stall) begin
      gap = diff >> 2;
      if (gap >= 32'(MAX_AHEAD)) allow = 0;
      else if (32'(MAX_AHEAD) - gap > 32'(WALK)) allow = WALK;
      else allow = int'(32'(MAX_AHEAD) - gap);
      npc = m_pc + 32'(4 * allow);
      for (int k = 0; k < allow; k++) begin
        spc = m_pc + 32'(4 * k);
        if (btb_hit[k]) begin
          if (br_kind[2*k +: 2] == K_COND && !br_taken[k]) continue;
          tgt = br_target[k*PC_W +: PC_W];
          if (br_kind[2*k +: 2] == K_CALL) begin
            for (int i = RAS_DEPTH - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
            m_stk[0] = spc + 4;
            if (m_cnt < RAS_DEPTH) m_cnt++;
          end else if (br_kind[2*k +: 2] == K_RET && m_cnt > 0) begin
            tgt = m_stk[0];
            for (int i = 0; i < RAS_DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
            m_cnt--;
          end
          npc = tgt;
          break;
        end else if (ld_hit[k] && ld_mc[k] && ld_ac[k] &&
                     (ld_last[k*PC_W +: PC_W] >> 6) != (ld_pred[k*PC_W +: PC_W] >> 6)) begin
          fire = 1'b1; faddr = ld_pred[k*PC_W +: PC_W];
          npc = spc + 4;
          break;
        end
      end
    end
    m_pc = npc;
    if (fire) begin
      m_pfv = 1'b1; m_pfa = faddr;
    end
  endtask

  // advance one clock; inputs already driven, outputs sampled at the negedge
  task automatic step();
    m_step();
    @(posedge clk);
    @(negedge clk);
    check_eq("R4 model pc", slot_pc(0), m_pc);
    check_eq("R2 slot3 lookup", slot_pc(WALK-1), m_pc + 32'(4*(WALK-1)));
    check_eq("R12 model pf_valid", 32'(pf_valid), 32'(m_pfv));
    if (m_pfv) check_eq("R6 model pf_addr", pf_addr, m_pfa);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, c;
    int r;
    void'($urandom(32'd20240611));
    clear_resp();
    m_pc = RESET_PC; m_pfv = 1'b0; m_pfa = '0; m_cnt = 0;
    for (int i = 0; i < RAS_DEPTH; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset pf_valid", 32'(pf_valid), 32'd0);
    check_eq("R1 reset pc", slot_pc(0), RESET_PC);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 pc held", slot_pc(0), RESET_PC);
    check_eq("R2 slot3 offset", slot_pc(3), RESET_PC + 32'hC);

    // R3 nothing hits
    proc_pc = m_pc; clear_resp(); step();
    check_eq("R3 skip", slot_pc(0), 32'h1010);

    // R4 taken branch hides the later load
    proc_pc = m_pc; clear_resp();
    set_br(1, K_COND, 1'b1, 32'h2000);
    set_ld(2, 1'b1, 1'b1, 32'h5000, 32'h5040);
    step();
    check_eq("R4 target", slot_pc(0), 32'h2000);
    check_eq("R4 no pf after taken", 32'(pf_valid), 32'd0);

    // R5 not taken
    proc_pc = m_pc; clear_resp();
    set_br(0, K_COND, 1'b0, 32'h9999_0000);
    step();
    check_eq("R5 not taken", slot_pc(0), 32'h2010);

    // R6 eligible load
    proc_pc = m_pc; clear_resp();
    set_ld(1, 1'b1, 1'b1, 32'h5000, 32'h5040);
    step();
    check_eq("R6 pf_valid", 32'(pf_valid), 32'd1);
    check_eq("R6 pf_addr", pf_addr, 32'h5040);
    check_eq("R6 walk ends after load", slot_pc(0), 32'h2018);

    // R12 back-pressure
    pf_ready = 1'b0; clear_resp(); step();
    check_eq("R12 held valid", 32'(pf_valid), 32'd1);
    check_eq("R12 held addr", pf_addr, 32'h5040);
    check_eq("R12 pc stalled", slot_pc(0), 32'h2018);
    pf_ready = 1'b1; proc_pc = m_pc; step();
    check_eq("R12 accepted", 32'(pf_valid), 32'd0);
    check_eq("R12 walk resumes", slot_pc(0), 32'h2028);

    // R6 ineligible loads
    proc_pc = m_pc; clear_resp();
    set_ld(0, 1'b1, 1'b1, 32'h5000, 32'h5008);
    set_ld(1, 1'b1, 1'b0, 32'h5000, 32'h5040);
    set_ld(2, 1'b0, 1'b1, 32'h5000, 32'h5040);
    step();
    check_eq("R6 no pf", 32'(pf_valid), 32'd0);
    check_eq("R6 walk continues", slot_pc(0), 32'h2038);

    // R10 call then return
    proc_pc = m_pc; clear_resp();
    set_br(2, K_CALL, 1'b0, 32'h3000);
    step();
    check_eq("R10 call target", slot_pc(0), 32'h3000);
    proc_pc = m_pc; clear_resp();
    set_br(0, K_RET, 1'b0, 32'h0BAD_0000);
    step();
    check_eq("R10 return addr", slot_pc(0), 32'h2044);
    proc_pc = m_pc; clear_resp();
    set_br(0, K_RET, 1'b1, 32'h4000);
    step();
    check_eq("R10 empty return", slot_pc(0), 32'h4000);

    // R11 overflow: 9 calls, 9 returns
    for (int i = 0; i < 9; i++) begin
      c = 32'h4000 + 32'(i) * 32'h100;
      proc_pc = m_pc; clear_resp();
      set_br(0, K_CALL, 1'b1, c + 32'h100);
      step();
    end
    check_eq("R11 after calls", slot_pc(0), 32'h4900);
    for (int j = 0; j < 8; j++) begin
      proc_pc = m_pc; clear_resp();
      set_br(0, K_RET, 1'b0, 32'h0BAD_0000);
      step();
      check_eq("R11 pop order", slot_pc(0), 32'h4000 + 32'(8 - j) * 32'h100 + 32'h4);
    end
    proc_pc = m_pc; clear_resp();
    set_br(0, K_RET, 1'b0, 32'h7000);
    step();
    check_eq("R11 oldest lost", slot_pc(0), 32'h7000);

    // R7 distance cap
    proc_pc = 32'h7000; clear_resp();
    repeat (30) step();
    check_eq("R7 capped", slot_pc(0), 32'h7190);
    proc_pc = 32'h7008; step();
    check_eq("R7 partial group", slot_pc(0), 32'h7198);

    // R9 processor overtakes
    proc_pc = 32'h8000; step();
    check_eq("R9 lag resync", slot_pc(0), 32'h8000);

    // R8 mispredict resets PC and empties stack
    clear_resp(); set_br(0, K_CALL, 1'b1, 32'h8100); step();
    clear_resp(); proc_pc = 32'h8100; mispredict = 1'b1; fix_pc = 32'h9000; step();
    check_eq("R8 fix pc", slot_pc(0), 32'h9000);
    mispredict = 1'b0; proc_pc = m_pc;
    set_br(0, K_RET, 1'b0, 32'hA000); step();
    check_eq("R8 stack cleared", slot_pc(0), 32'hA000);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      clear_resp();
      mispredict = 1'b0;
      r = $urandom_range(0, 99);
      if (r < 3) begin
        mispredict = 1'b1;
        fix_pc = 32'h0001_0000 + 32'(4 * $urandom_range(0, 4095));
        proc_pc = m_pc;
      end else if (r < 8) proc_pc = m_pc + 32'(4 * $urandom_range(1, 8));
      else proc_pc = m_pc - 32'(4 * $urandom_range(0, 110));
      for (int k = 0; k < WALK; k++) begin
        base = m_pc + 32'(4 * k);
        r = $urandom_range(0, 99);
        if (r < 15) begin
          if ($urandom_range(0, 9) == 0) c = base - 32'(4 * $urandom_range(1, 30));
          else c = base + 32'(4 * $urandom_range(1, 30));
          set_br(k, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), c);
        end else if (r < 45) begin
          c = $urandom() & 32'h00FF_FFFC;
          set_ld(k, 1'($urandom_range(0, 99) < 85), 1'($urandom_range(0, 99) < 85),
                 c, c + 32'(4 * $urandom_range(0, 31)));
        end
      end
      pf_ready = 1'($urandom_range(0, 99) < 60);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule